// File: doc/BRIEF.md
# Strip Module Event Serializer

This block builds the serial bit stream that a strip-readout module drives onto its data link for every accepted trigger. A trigger pulse carries a 4-bit L1-ID, an 8-bit BC-ID and a 16-bit mask that marks which front-end chips take part in the event. A hit list is written separately into an internal FIFO. Each entry holds a chip number, a channel number and three bunch-crossing bits. The list is closed by an end marker. For each event the block sends a fixed header and the two counters. It then sends hit packets chip by chip, and finally a trailer. The output is one bit per clock.

Hits on neighbouring channels of the same chip are sent as short continuation packets. An active chip with no hits sends a short placeholder packet. Triggers that arrive while an event is still being sent wait in a small queue. An event does not start until its hit list has been closed. Consecutive events therefore leave the link back to back, with no idle bits between them.

Top module: `strip_event_serializer`

## Requirements
- R1: While no event is being sent, `busy` is 0 and `serOut` is held at 0. After reset both outputs are 0.
- R2: Every event opens with the 19 bits `111010`, then the L1-ID (4 bits, MSB first), then the BC-ID (8 bits, MSB first), then a single 1.
- R3: The first hit on a chip is sent as 17 bits: `01`, the chip number (4 bits), the channel (7 bits), a 1, and the bunch-crossing bits (3 bits). All fields go MSB first.
- R4: A hit whose channel is exactly one above the previous hit's channel on the same chip is sent as 4 bits: a 1 followed by its 3 bunch-crossing bits.
- R5: A chip whose mask bit is 1 and which has no hits sends `001`. A chip whose mask bit is 0 sends nothing. Mask bit i stands for chip i.
- R6: Chips are served in ascending chip number. Hits within a chip are sent in the order they were written, which must be ascending channel order.
- R7: Every event closes with a 1 followed by 15 zeros. An event with an all-zero mask is exactly 35 bits long.
- R8: `busy` is 1 from the first header bit through the last trailer bit, with no gap inside an event.
- R9: Up to 4 triggers that arrive while the serializer is busy are kept in order. Each queued event follows the previous one back to back, so `busy` does not drop between them.
- R10: An event does not start before the end marker of its hit list has been written. Until then, `busy` stays 0.
- R11: A hit on a chip different from the previous hit's chip is always sent as a full 17-bit packet, even if its channel is one above the previous hit's channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigIn | input | 1 | Trigger accepted, one-cycle pulse |
| trigL1Id | input | 4 | L1-ID of the triggered event |
| trigBcId | input | 8 | BC-ID of the triggered event |
| trigChipMask | input | 16 | Chips taking part in the event, bit i = chip i |
| hitWrite | input | 1 | Write one entry into the hit list FIFO |
| hitEnd | input | 1 | Entry is the end marker of the current event's list |
| hitChip | input | 4 | Chip number of the hit |
| hitChan | input | 7 | Channel number of the hit |
| hitBx | input | 3 | Bunch-crossing bits (previous, current, next) |
| serOut | output | 1 | Serial data, one bit per clock |
| busy | output | 1 | High while an event is on the line |

## Verification
Some behaviours are checked by assertions on every cycle. The line stays at 0 whenever `busy` is low. The first bit under `busy` is a 1 and the last one is a 0. The shifter never runs empty while an event is in progress. Hit entries are only consumed from a closed list, and the queues are never written when full.

The exact bit content can only be shown by the bench scenarios, which compare the captured stream against frames built from the requirements. These scenarios cover header fields, full hit packets versus continuations, placeholders, chip ordering, and back-to-back queued events. Whether an event waits for a late hit list is also shown only there.

// File: rtl/strip_ser_pkg.sv
package strip_ser_pkg;
  localparam int CHIP_W    = 4;
  localparam int CHAN_W    = 7;
  localparam int BX_W      = 3;
  localparam int L1_W      = 4;
  localparam int BC_W      = 8;
  localparam int NUM_CHIPS = 1 << CHIP_W;

  localparam logic [5:0] HDR_CODE = 6'b111010;
  localparam int HDR_LEN   = 6 + L1_W + BC_W + 1;
  localparam int FULL_LEN  = 2 + CHIP_W + CHAN_W + 1 + BX_W;
  localparam int CONT_LEN  = 1 + BX_W;
  localparam int NOHIT_LEN = 3;
  localparam int TRAIL_LEN = 16;
  localparam int PKT_W     = HDR_LEN;
  localparam int LEN_W     = $clog2(PKT_W + 1);

  typedef struct packed {
    logic              isEnd;
    logic [CHIP_W-1:0] chip;
    logic [CHAN_W-1:0] chan;
    logic [BX_W-1:0]   bx;
  } hitEntry_t;

  typedef struct packed {
    logic [L1_W-1:0]      l1Id;
    logic [BC_W-1:0]      bcId;
    logic [NUM_CHIPS-1:0] mask;
  } trigEntry_t;

  typedef struct packed {
    logic             load;
    logic [PKT_W-1:0] pkt;
    logic [LEN_W-1:0] len;
    logic             popHit;
    logic             popTrig;
  } serStrobe_t;
endpackage

// File: rtl/strip_ser_fifo.sv
module strip_ser_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == (AW+1)'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + (AW+1)'(doPush) - (AW+1)'(doPop);
    end
  end
endmodule

// File: rtl/strip_ser_datapath.sv
module strip_ser_datapath
  import strip_ser_pkg::*;
#(
  parameter int TRIG_DEPTH = 4,
  parameter int HIT_DEPTH  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigIn,
  input  trigEntry_t       trigData,
  input  logic             hitWrite,
  input  hitEntry_t        hitData,
  input  serStrobe_t       strobe,
  output trigEntry_t       trigHead,
  output logic             trigReady,
  output hitEntry_t        hitHead,
  output logic             listReady,
  output logic [LEN_W-1:0] shCnt,
  output logic             serOut,
  output logic             busy
);
  localparam int LIST_W = $clog2(HIT_DEPTH + 1);

  logic trigEmpty, trigFull, hitEmpty, hitFull;
  logic [LIST_W-1:0] listCnt;
  logic [PKT_W-1:0]  shData;
  logic listInc, listDec;

  strip_ser_fifo #(.WIDTH($bits(trigEntry_t)), .DEPTH(TRIG_DEPTH)) u_trigQ (
    .clk(clk), .rst_n(rst_n), .push(trigIn), .pushData(trigData),
    .pop(strobe.popTrig), .headData(trigHead), .empty(trigEmpty), .full(trigFull));

  strip_ser_fifo #(.WIDTH($bits(hitEntry_t)), .DEPTH(HIT_DEPTH)) u_hitQ (
    .clk(clk), .rst_n(rst_n), .push(hitWrite), .pushData(hitData),
    .pop(strobe.popHit), .headData(hitHead), .empty(hitEmpty), .full(hitFull));

  assign trigReady = !trigEmpty;
  assign listInc   = hitWrite && hitData.isEnd && !hitFull;
  assign listDec   = strobe.popHit && hitHead.isEnd;
  assign listReady = (listCnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) listCnt <= '0;
    else        listCnt <= listCnt + LIST_W'(listInc) - LIST_W'(listDec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shData <= '0;
      shCnt  <= '0;
      serOut <= 1'b0;
      busy   <= 1'b0;
    end else begin
      serOut <= (shCnt != '0) && shData[PKT_W-1];
      busy   <= (shCnt != '0);
      if (strobe.load) begin
        shData <= strobe.pkt;
        shCnt  <= strobe.len;
      end else if (shCnt != '0) begin
        shData <= {shData[PKT_W-2:0], 1'b0};
        shCnt  <= shCnt - 1'b1;
      end
    end
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !serOut);
  a_r2_header_first_one: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> serOut);
  a_r7_trailer_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(serOut));
  a_r9_trig_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    trigIn |-> !trigFull);
  a_r10_pop_closed_list: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.popHit |-> (listCnt != '0) && !hitEmpty);
endmodule

// File: rtl/strip_ser_ctrl.sv
module strip_ser_ctrl
  import strip_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  trigEntry_t       trigHead,
  input  logic             trigReady,
  input  hitEntry_t        hitHead,
  input  logic             listReady,
  input  logic [LEN_W-1:0] shCnt,
  output serStrobe_t       strobe
);
  typedef enum logic {ST_IDLE, ST_CHIPS} phase_t;

  phase_t               state, nState;
  logic [CHIP_W-1:0]    curChip, nCurChip, nextChip;
  logic                 served, nServed, found;
  logic [CHAN_W-1:0]    prevChan, nPrevChan;
  logic [NUM_CHIPS-1:0] evMask, nMask;
  logic [CHIP_W:0]      searchBase;
  logic                 want, popHit, popTrig, trailerSel, load;
  logic [PKT_W-1:0]     pkt;
  logic [LEN_W-1:0]     len;

  assign searchBase = served ? {1'b0, curChip} + 1'b1 : {1'b0, curChip};

  always_comb begin
    found    = 1'b0;
    nextChip = '0;
    for (int i = NUM_CHIPS-1; i >= 0; i--) begin
      if (evMask[i] && ((CHIP_W+1)'(i) >= searchBase)) begin
        found    = 1'b1;
        nextChip = CHIP_W'(i);
      end
    end
  end

  always_comb begin
    want = 1'b0; popHit = 1'b0; popTrig = 1'b0; trailerSel = 1'b0;
    pkt = '0; len = '0;
    nState = state; nCurChip = curChip; nServed = served;
    nPrevChan = prevChan; nMask = evMask;
    if (state == ST_IDLE) begin
      if (trigReady && listReady) begin
        want = 1'b1; popTrig = 1'b1;
        pkt  = {HDR_CODE, trigHead.l1Id, trigHead.bcId, 1'b1};
        len  = LEN_W'(HDR_LEN);
        nState = ST_CHIPS; nCurChip = '0; nServed = 1'b0;
        nMask = trigHead.mask;
      end
    end else if (!hitHead.isEnd && served && hitHead.chip == curChip) begin
      want = 1'b1; popHit = 1'b1; nPrevChan = hitHead.chan;
      if ({1'b0, hitHead.chan} == {1'b0, prevChan} + 1'b1) begin
        pkt = {1'b1, hitHead.bx, {(PKT_W-CONT_LEN){1'b0}}};
        len = LEN_W'(CONT_LEN);
      end else begin
        pkt = {2'b01, hitHead.chip, hitHead.chan, 1'b1, hitHead.bx,
               {(PKT_W-FULL_LEN){1'b0}}};
        len = LEN_W'(FULL_LEN);
      end
    end else if (found) begin
      want = 1'b1; nCurChip = nextChip; nServed = 1'b1;
      if (!hitHead.isEnd && hitHead.chip == nextChip) begin
        popHit = 1'b1; nPrevChan = hitHead.chan;
        pkt = {2'b01, hitHead.chip, hitHead.chan, 1'b1, hitHead.bx,
               {(PKT_W-FULL_LEN){1'b0}}};
        len = LEN_W'(FULL_LEN);
      end else begin
        pkt = {3'b001, {(PKT_W-NOHIT_LEN){1'b0}}};
        len = LEN_W'(NOHIT_LEN);
      end
    end else begin
      want = 1'b1; popHit = 1'b1; trailerSel = 1'b1;
      pkt = {1'b1, {(PKT_W-1){1'b0}}};
      len = LEN_W'(TRAIL_LEN);
      nState = ST_IDLE;
    end
  end

  assign load = want && (shCnt <= LEN_W'(1));

  always_comb begin
    strobe.load    = load;
    strobe.pkt     = pkt;
    strobe.len     = len;
    strobe.popHit  = load && popHit;
    strobe.popTrig = load && popTrig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; curChip <= '0; served <= 1'b0;
      prevChan <= '0; evMask <= '0;
    end else if (load) begin
      state <= nState; curChip <= nCurChip; served <= nServed;
      prevChan <= nPrevChan; evMask <= nMask;
    end
  end

  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHIPS) |-> (shCnt != '0));
  a_r7_trailer_on_end_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (load && trailerSel) |-> hitHead.isEnd);
endmodule

// File: rtl/strip_event_serializer.sv
module strip_event_serializer
  import strip_ser_pkg::*;
#(
  parameter int TRIG_DEPTH = 4,
  parameter int HIT_DEPTH  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trigIn,
  input  logic [L1_W-1:0]      trigL1Id,
  input  logic [BC_W-1:0]      trigBcId,
  input  logic [NUM_CHIPS-1:0] trigChipMask,
  input  logic                 hitWrite,
  input  logic                 hitEnd,
  input  logic [CHIP_W-1:0]    hitChip,
  input  logic [CHAN_W-1:0]    hitChan,
  input  logic [BX_W-1:0]      hitBx,
  output logic                 serOut,
  output logic                 busy
);
  trigEntry_t       trigData, trigHead;
  hitEntry_t        hitData, hitHead;
  serStrobe_t       strobe;
  logic             trigReady, listReady;
  logic [LEN_W-1:0] shCnt;

  assign trigData = '{l1Id: trigL1Id, bcId: trigBcId, mask: trigChipMask};
  assign hitData  = '{isEnd: hitEnd, chip: hitChip, chan: hitChan, bx: hitBx};

  strip_ser_datapath #(.TRIG_DEPTH(TRIG_DEPTH), .HIT_DEPTH(HIT_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .trigData(trigData),
    .hitWrite(hitWrite), .hitData(hitData), .strobe(strobe),
    .trigHead(trigHead), .trigReady(trigReady), .hitHead(hitHead),
    .listReady(listReady), .shCnt(shCnt), .serOut(serOut), .busy(busy));

  strip_ser_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trigHead(trigHead), .trigReady(trigReady),
    .hitHead(hitHead), .listReady(listReady), .shCnt(shCnt), .strobe(strobe));
endmodule

// File: tb/strip_event_serializer_tb.sv
`timescale 1ns/1ps
module strip_event_serializer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trigIn = 1'b0;
  logic [3:0] trigL1Id = '0;
  logic [7:0] trigBcId = '0;
  logic [15:0] trigChipMask = '0;
  logic hitWrite = 1'b0, hitEnd = 1'b0;
  logic [3:0] hitChip = '0;
  logic [6:0] hitChan = '0;
  logic [2:0] hitBx = '0;
  logic serOut, busy;

  always #2.5 clk = ~clk;

  strip_event_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .trigL1Id(trigL1Id),
    .trigBcId(trigBcId), .trigChipMask(trigChipMask), .hitWrite(hitWrite),
    .hitEnd(hitEnd), .hitChip(hitChip), .hitChan(hitChan), .hitBx(hitBx),
    .serOut(serOut), .busy(busy));

  int checks = 0, fails = 0;
  bit capQ[$], expQ[$];
  int riseCnt = 0, idleErr = 0;
  logic prevBusy = 1'b0;
  int hC[$], hN[$], hB[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) capQ.push_back(serOut);
      else if (serOut) idleErr++;
      if (busy && !prevBusy) riseCnt++;
      prevBusy = busy;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushBits(logic [31:0] v, int n);
    for (int i = n-1; i >= 0; i--) expQ.push_back(v[i]);
  endtask

  task automatic addHit(int c, int n, int b);
    hC.push_back(c); hN.push_back(n); hB.push_back(b);
  endtask

  task automatic modelEvent(int l1, int bc, logic [15:0] mask);
    pushBits(32'h3A, 6); pushBits(l1, 4); pushBits(bc, 8); pushBits(1, 1);
    for (int c = 0; c < 16; c++) begin
      if (mask[c]) begin
        bit any = 0;
        int prev = -5;
        for (int k = 0; k < hC.size(); k++) begin
          if (hC[k] == c) begin
            if (any && hN[k] == prev + 1) begin
              pushBits(1, 1); pushBits(hB[k], 3);
            end else begin
              pushBits(1, 2); pushBits(c, 4); pushBits(hN[k], 7);
              pushBits(1, 1); pushBits(hB[k], 3);
            end
            prev = hN[k];
            any = 1;
          end
        end
        if (!any) pushBits(1, 3);
      end
    end
    pushBits(32'h8000, 16);
  endtask

  task automatic loadList();
    for (int k = 0; k < hC.size(); k++) begin
      @(negedge clk);
      hitWrite = 1; hitEnd = 0;
      hitChip = 4'(hC[k]); hitChan = 7'(hN[k]); hitBx = 3'(hB[k]);
    end
    @(negedge clk);
    hitWrite = 1; hitEnd = 1;
    @(negedge clk);
    hitWrite = 0; hitEnd = 0;
    hC.delete(); hN.delete(); hB.delete();
  endtask

  task automatic sendTrig(int l1, int bc, logic [15:0] mask);
    @(negedge clk);
    trigIn = 1; trigL1Id = 4'(l1); trigBcId = 8'(bc); trigChipMask = mask;
  endtask

  task automatic endTrig();
    @(negedge clk);
    trigIn = 0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 30) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic compareStream(string tag, int expRises);
    int bad = -1;
    check({tag, " length"}, capQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < capQ.size(); i++)
      if (bad < 0 && capQ[i] != expQ[i]) bad = i;
    if (bad >= 0) check({tag, " bit mismatch at index"}, bad, -1);
    else check({tag, " content"}, 0, 0);
    check({tag, " busy windows"}, riseCnt, expRises);
    capQ.delete(); expQ.delete(); riseCnt = 0;
  endtask

  task automatic runOne(string tag, int l1, int bc, logic [15:0] mask);
    modelEvent(l1, bc, mask);
    loadList();
    sendTrig(l1, bc, mask);
    endTrig();
    waitIdle();
    compareStream(tag, 1);
  endtask

  task automatic t_reset();
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset serOut", int'(serOut), 0);
  endtask

  task automatic t_empty();
    modelEvent(5, 8'hA3, 16'h0000);
    loadList();
    sendTrig(5, 8'hA3, 16'h0000);
    endTrig();
    waitIdle();
    check("R7 minimal event 35 bits", capQ.size(), 35);
    compareStream("R2 R7 R8 empty event", 1);
  endtask

  task automatic t_nohit();
    runOne("R5 placeholders chips 0,3,15", 9, 8'h3C, 16'h8009);
  endtask

  task automatic t_single();
    addHit(2, 8'h55, 3'b010);
    runOne("R3 single full hit", 12, 8'hF0, 16'h0004);
  endtask

  task automatic t_cluster();
    addHit(1, 10, 1); addHit(1, 11, 4); addHit(1, 12, 7); addHit(1, 20, 2);
    runOne("R4 continuation run and gap", 3, 8'h11, 16'h0002);
  endtask

  task automatic t_crossChip();
    addHit(3, 5, 6); addHit(5, 6, 5);
    runOne("R11 adjacent channel other chip", 7, 8'h80, 16'h0028);
  endtask

  task automatic t_order();
    addHit(7, 0, 1); addHit(7, 1, 2); addHit(7, 127, 3);
    addHit(12, 64, 4);
    runOne("R6 ascending chips with placeholders", 15, 8'h01, 16'h1281);
  endtask

  task automatic t_queue();
    addHit(0, 4, 3);
    modelEvent(1, 8'h10, 16'h0001); loadList();
    addHit(6, 30, 1); addHit(6, 31, 1);
    modelEvent(2, 8'h20, 16'h0041); loadList();
    modelEvent(3, 8'h30, 16'h0000); loadList();
    addHit(15, 100, 6);
    modelEvent(4, 8'h40, 16'h8000); loadList();
    sendTrig(1, 8'h10, 16'h0001);
    sendTrig(2, 8'h20, 16'h0041);
    sendTrig(3, 8'h30, 16'h0000);
    sendTrig(4, 8'h40, 16'h8000);
    endTrig();
    waitIdle();
    compareStream("R9 four queued events back to back", 1);
  endtask

  task automatic t_wait();
    int sawBusy = 0;
    sendTrig(6, 8'h66, 16'h0010);
    endTrig();
    repeat (20) begin
      @(negedge clk);
      if (busy) sawBusy = 1;
    end
    check("R10 no start before list closed", sawBusy, 0);
    addHit(4, 9, 7);
    modelEvent(6, 8'h66, 16'h0010);
    loadList();
    waitIdle();
    compareStream("R10 late list event", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_empty();
    t_nohit();
    t_single();
    t_cluster();
    t_crossChip();
    t_order();
    t_queue();
    t_wait();
    check("R1 line low while idle", idleErr, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule